// File: doc/BRIEF.md
# Timer Input Capture Unit with Noise Filter

This block records the value of a free-running timer whenever a chosen edge appears on a trigger signal. The trigger is taken either from an external capture pin or from the output of an analog comparator, and a control bit chooses between them. Both candidates pass through a synchronizer. The selected one can then go through a noise filter that changes its output only after four identical consecutive system-clock samples. A rising or falling edge detector follows, and it loads the timer value into a capture register.

Each capture sets a sticky capture flag. Software clears the flag with a write-one strobe. An interrupt request is the flag gated by an enable bit. The timer counter, its prescaler and the comparator sit outside the block, and their values arrive as plain inputs. The filter always runs on the system clock.

The filter is a four-state machine: FL_LO (stable low), FL_RISE (qualifying a high level), FL_HI (stable high) and FL_FALL (qualifying a low level). A disagreeing sample sends FL_RISE back to FL_LO and FL_FALL back to FL_HI. A full run of agreeing samples moves FL_RISE to FL_HI and FL_FALL to FL_LO. The flag is a two-state machine. A capture event moves FG_CLEAR to FG_SET. A clear strobe in a cycle with no capture event moves FG_SET back to FG_CLEAR.

Top module: `tmr_input_capture`

## Requirements
- R1: After reset, cap_val_o is 0, and cap_flag_o and irq_o are 0.
- R2: With edge_rise_i=1 and the filter off, a rise on the selected trigger that is applied between clock edges k and k+1 loads the count_i value present at edge k+3 into cap_val_o (two synchronizer stages, then edge detection).
- R3: With edge_rise_i=0, only a falling trigger transition captures, with the same latency as R2.
- R4: src_cmp_i=1 selects cmp_out_i as the trigger and src_cmp_i=0 selects cap_pin_i. Transitions on the unselected input cause no capture.
- R5: Changing src_cmp_i while the two synchronized inputs differ is seen as a trigger transition. If it matches the selected edge, it captures at the next clock edge.
- R6: With filt_en_i=1, the capture happens four clock cycles later than in R2, which is edge k+7.
- R7: With filt_en_i=1, a trigger pulse that lasts fewer than four clock cycles causes no capture. A pulse that lasts four cycles does capture.
- R8: A new capture overwrites cap_val_o even when the flag is still set from an earlier capture.
- R9: Every capture sets cap_flag_o. A one-cycle flag_clr_i pulse in a cycle with no capture clears it.
- R10: When a capture and flag_clr_i fall in the same cycle, cap_flag_o stays set.
- R11: irq_o is high exactly when cap_flag_o and irq_en_i are both high.
- R12: A trigger transition opposite to the selected edge leaves cap_val_o and cap_flag_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin_i | input | 1 | External capture pin (asynchronous) |
| cmp_out_i | input | 1 | Analog comparator output (asynchronous) |
| src_cmp_i | input | 1 | 1: use comparator as trigger, 0: use pin |
| edge_rise_i | input | 1 | 1: capture on rising edge, 0: on falling edge |
| filt_en_i | input | 1 | Enable the four-sample noise filter |
| irq_en_i | input | 1 | Interrupt enable |
| flag_clr_i | input | 1 | Write-one strobe that clears the capture flag |
| count_i | input | TW | Current timer counter value |
| cap_val_o | output | TW | Capture register |
| cap_flag_o | output | 1 | Sticky capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench measures capture latency through the captured timer value itself. A latency that is one cycle wrong in the synchronizer, the filter or the edge detector shows up as a value off by one from the scoreboard entry. A filter that counts three samples instead of four would accept the three-cycle glitch. The scoreboard reports such a glitch as an unexpected capture, and it reports a filter that needs five samples as a missing one.

The bench also switches the trigger source while the two inputs differ. A design that places the multiplexer in front of the synchronizers would capture two cycles late. A design that ignores the switch would leave a scoreboard entry pending. Finally, the bench lines up a clear strobe with a capture in the same cycle. A flag machine that gives the clear priority would drop the flag there.

// File: rtl/icap_pkg.sv
package icap_pkg;

    // Noise filter qualification states
    typedef enum logic [1:0] {
        FL_LO   = 2'd0,
        FL_RISE = 2'd1,
        FL_HI   = 2'd2,
        FL_FALL = 2'd3
    } filt_st_t;

    // Capture flag states
    typedef enum logic {
        FG_CLEAR = 1'b0,
        FG_SET   = 1'b1
    } flag_st_t;

endpackage

// File: rtl/icap_sync.sv
module icap_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= d_i;
            for (int i = 1; i < STAGES; i++) begin
                chain_q[i] <= chain_q[i-1];
            end
        end
    end

    assign q_o = chain_q[STAGES-1];

endmodule

// File: rtl/icap_filter.sv
module icap_filter
    import icap_pkg::*;
#(
    parameter int FILT_LEN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    input  logic din_i,
    output logic lvl_o
);

    localparam int CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] LAST = CW'(FILT_LEN - 1);

    filt_st_t       state_q, state_n;
    logic [CW-1:0]  cnt_q, cnt_n;
    logic           filt_lvl;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= FL_LO;
            cnt_q   <= '0;
        end else begin
            state_q <= state_n;
            cnt_q   <= cnt_n;
        end
    end

    // Transitions
    always_comb begin
        state_n = state_q;
        cnt_n   = cnt_q;
        unique case (state_q)
            FL_LO: begin
                if (din_i) begin
                    state_n = FL_RISE;
                    cnt_n   = CW'(1);
                end
            end
            FL_RISE: begin
                if (!din_i) begin
                    state_n = FL_LO;
                    cnt_n   = '0;
                end else if (cnt_q == LAST) begin
                    state_n = FL_HI;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            FL_HI: begin
                if (!din_i) begin
                    state_n = FL_FALL;
                    cnt_n   = CW'(1);
                end
            end
            FL_FALL: begin
                if (din_i) begin
                    state_n = FL_HI;
                    cnt_n   = '0;
                end else if (cnt_q == LAST) begin
                    state_n = FL_LO;
                    cnt_n   = '0;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            default: begin
                state_n = FL_LO;
                cnt_n   = '0;
            end
        endcase
    end

    // Outputs
    always_comb begin
        filt_lvl = (state_q == FL_HI) || (state_q == FL_FALL);
        lvl_o    = en_i ? filt_lvl : din_i;
    end

    AST_FILT_RISE_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(filt_lvl) |-> $past(din_i)); // R7
    AST_FILT_FALL_AGREES: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(filt_lvl) |-> !$past(din_i)); // R7
    AST_FILT_FULL_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (filt_lvl != $past(filt_lvl)) |-> ($past(cnt_q) == LAST)); // R6

endmodule

// File: rtl/icap_edge_cap.sv
module icap_edge_cap
    import icap_pkg::*;
#(
    parameter int TW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          lvl_i,
    input  logic          rise_sel_i,
    input  logic          clr_i,
    input  logic [TW-1:0] count_i,
    output logic [TW-1:0] cap_o,
    output logic          flag_o
);

    logic          prev_q;
    logic          evt;
    logic [TW-1:0] cap_q;
    flag_st_t      flag_q, flag_n;

    always_comb begin
        evt = rise_sel_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b0;
            cap_q  <= '0;
            flag_q <= FG_CLEAR;
        end else begin
            prev_q <= lvl_i;
            if (evt) cap_q <= count_i;
            flag_q <= flag_n;
        end
    end

    // Flag transitions: a capture event wins over a clear strobe
    always_comb begin
        flag_n = flag_q;
        unique case (flag_q)
            FG_CLEAR: if (evt) flag_n = FG_SET;
            FG_SET:   if (clr_i && !evt) flag_n = FG_CLEAR;
            default:  flag_n = FG_CLEAR;
        endcase
    end

    // Outputs
    always_comb begin
        cap_o  = cap_q;
        flag_o = (flag_q == FG_SET);
    end

    AST_CAP_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt) |-> (cap_o == $past(count_i))); // R8
    AST_CAP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(evt) |-> $stable(cap_o)); // R12
    AST_FLAG_ON_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(evt) |-> flag_o); // R9
    AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i && !evt) |-> !flag_o); // R9
    AST_CAPTURE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clr_i && evt) |-> flag_o); // R10

endmodule

// File: rtl/tmr_input_capture.sv
module tmr_input_capture #(
    parameter int TW          = 16,
    parameter int SYNC_STAGES = 2,
    parameter int FILT_LEN    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap_pin_i,
    input  logic          cmp_out_i,
    input  logic          src_cmp_i,
    input  logic          edge_rise_i,
    input  logic          filt_en_i,
    input  logic          irq_en_i,
    input  logic          flag_clr_i,
    input  logic [TW-1:0] count_i,
    output logic [TW-1:0] cap_val_o,
    output logic          cap_flag_o,
    output logic          irq_o
);

    localparam int N_SRC = 2;

    logic [N_SRC-1:0] raw_in;
    logic [N_SRC-1:0] synced;
    logic             trig_lvl;
    logic             clean_lvl;

    assign raw_in = {cmp_out_i, cap_pin_i};

    icap_sync #(.W(N_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (synced)
    );

    // Source select after synchronization: a switch is seen at once
    assign trig_lvl = src_cmp_i ? synced[1] : synced[0];

    icap_filter #(.FILT_LEN(FILT_LEN)) u_filt (
        .clk   (clk),
        .rst_n (rst_n),
        .en_i  (filt_en_i),
        .din_i (trig_lvl),
        .lvl_o (clean_lvl)
    );

    icap_edge_cap #(.TW(TW)) u_cap (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl_i      (clean_lvl),
        .rise_sel_i (edge_rise_i),
        .clr_i      (flag_clr_i),
        .count_i    (count_i),
        .cap_o      (cap_val_o),
        .flag_o     (cap_flag_o)
    );

    assign irq_o = cap_flag_o & irq_en_i;

    AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> cap_flag_o); // R11
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> irq_en_i); // R11

endmodule

// File: tb/sim_tmr_input_capture.sv
module sim_tmr_input_capture;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cap_pin = 1'b0, cmp_out = 1'b0, src_cmp = 1'b0;
    logic          edge_rise = 1'b1, filt_en = 1'b0, irq_en = 1'b0, flag_clr = 1'b0;
    logic [TW-1:0] count = '0;
    logic [TW-1:0] cap_val;
    logic          cap_flag, irq;

    int checks = 0;
    int errors = 0;
    bit started = 0;
    bit done = 0;

    typedef struct {
        logic [TW-1:0] val;
        string         tag;
    } exp_t;

    exp_t          sb_q[$];
    logic [TW-1:0] last_seen = '0;
    logic [TW-1:0] last_exp  = '0;
    string         cur_tag   = "R1";

    tmr_input_capture #(.TW(TW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_pin_i   (cap_pin),
        .cmp_out_i   (cmp_out),
        .src_cmp_i   (src_cmp),
        .edge_rise_i (edge_rise),
        .filt_en_i   (filt_en),
        .irq_en_i    (irq_en),
        .flag_clr_i  (flag_clr),
        .count_i     (count),
        .cap_val_o   (cap_val),
        .cap_flag_o  (cap_flag),
        .irq_o       (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Free-running timer model, advanced away from the active edge
    always @(negedge clk) count <= count + 1'b1;

    task automatic check(input string tag, input logic [TW-1:0] act, input logic [TW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: pop an expected item for each change of the capture register
    always @(negedge clk) begin
        if (started && cap_val !== last_seen) begin
            checks++;
            if (sb_q.size() == 0) begin
                errors++;
                $display("FAIL %s unexpected capture actual %h expected none", cur_tag, cap_val);
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                if (cap_val !== e.val) begin
                    errors++;
                    $display("FAIL %s capture actual %h expected %h", e.tag, cap_val, e.val);
                end
            end
            last_seen = cap_val;
        end
    end

    task automatic push_exp(input int lat, input string tag);
        exp_t e;
        e.val = count + TW'(lat);
        e.tag = tag;
        last_exp = e.val;
        sb_q.push_back(e);
    endtask

    // Driver: change a trigger input between edges, optionally expect a capture
    task automatic drive_pin(input logic v, input bit expect_cap, input int lat, input string tag);
        @(negedge clk); #1;
        cur_tag = tag;
        if (expect_cap) push_exp(lat, tag);
        cap_pin = v;
    endtask

    task automatic drive_cmp(input logic v, input bit expect_cap, input int lat, input string tag);
        @(negedge clk); #1;
        cur_tag = tag;
        if (expect_cap) push_exp(lat, tag);
        cmp_out = v;
    endtask

    task automatic drive_src(input logic v, input bit expect_cap, input string tag);
        @(negedge clk); #1;
        cur_tag = tag;
        if (expect_cap) push_exp(0, tag);
        src_cmp = v;
    endtask

    task automatic settle(input int n, input string tag);
        repeat (n) @(negedge clk);
        checks++;
        if (sb_q.size() != 0) begin
            errors++;
            $display("FAIL %s missing capture actual pending %0d expected 0", tag, sb_q.size());
            sb_q.delete();
        end
    endtask

    task automatic pulse_clr();
        @(negedge clk); #1 flag_clr = 1'b1;
        @(negedge clk); #1 flag_clr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1", cap_val, '0);
        check("R1", TW'(cap_flag), '0);
        check("R1", TW'(irq), '0);
        #1 rst_n = 1'b1;
        repeat (2) @(negedge clk);
        started = 1;

        // R2 rising edge on pin, filter off
        drive_pin(1'b1, 1, 2, "R2");
        settle(8, "R2");
        check("R9", TW'(cap_flag), 1);
        check("R11", TW'(irq), 0);
        @(negedge clk); #1 irq_en = 1'b1;
        @(negedge clk);
        check("R11", TW'(irq), 1);
        pulse_clr();
        @(negedge clk);
        check("R9", TW'(cap_flag), 0);
        check("R11", TW'(irq), 0);

        // R12 opposite edge ignored
        drive_pin(1'b0, 0, 0, "R12");
        settle(8, "R12");
        check("R12", cap_val, last_exp);
        check("R12", TW'(cap_flag), 0);

        // R3 falling edge selection
        @(negedge clk); #1 edge_rise = 1'b0;
        drive_pin(1'b1, 0, 0, "R3");
        settle(8, "R3");
        check("R3", TW'(cap_flag), 0);
        drive_pin(1'b0, 1, 2, "R3");
        settle(8, "R3");
        check("R3", TW'(cap_flag), 1);

        // R8 overwrite without clearing
        @(negedge clk); #1 edge_rise = 1'b1;
        drive_pin(1'b1, 1, 2, "R8");
        settle(8, "R8");
        drive_pin(1'b0, 0, 0, "R8");
        settle(6, "R8");
        drive_pin(1'b1, 1, 2, "R8");
        settle(8, "R8");
        check("R8", cap_val, last_exp);
        check("R8", TW'(cap_flag), 1);

        // R6 filter latency
        @(negedge clk); #1 filt_en = 1'b1;
        drive_pin(1'b0, 0, 0, "R6");
        settle(10, "R6");
        drive_pin(1'b1, 1, 6, "R6");
        settle(12, "R6");
        drive_pin(1'b0, 0, 0, "R6");
        settle(10, "R6");

        // R7 three-cycle glitch rejected, four-cycle pulse accepted
        drive_pin(1'b1, 0, 0, "R7");
        repeat (2) @(negedge clk);
        drive_pin(1'b0, 0, 0, "R7");
        settle(12, "R7");
        check("R7", cap_val, last_exp);
        drive_pin(1'b1, 1, 6, "R7");
        repeat (3) @(negedge clk);
        drive_pin(1'b0, 0, 0, "R7");
        settle(12, "R7");

        // R4 comparator selected, pin ignored
        @(negedge clk); #1 filt_en = 1'b0;
        drive_src(1'b1, 0, "R4");
        settle(4, "R4");
        drive_pin(1'b1, 0, 0, "R4");
        settle(8, "R4");
        check("R4", cap_val, last_exp);
        drive_cmp(1'b1, 1, 2, "R4");
        settle(8, "R4");

        // R5 source switch produces a capture
        drive_pin(1'b0, 0, 0, "R5");
        settle(6, "R5");
        drive_src(1'b0, 0, "R5");
        settle(4, "R5");
        drive_src(1'b1, 1, "R5");
        settle(4, "R5");

        // R10 capture and clear in the same cycle
        drive_cmp(1'b0, 0, 0, "R10");
        settle(6, "R10");
        pulse_clr();
        @(negedge clk);
        check("R9", TW'(cap_flag), 0);
        drive_cmp(1'b1, 1, 2, "R10");
        @(negedge clk);
        @(negedge clk); #1 flag_clr = 1'b1;
        @(negedge clk); #1 flag_clr = 1'b0;
        settle(4, "R10");
        check("R10", TW'(cap_flag), 1);
        check("R11", TW'(irq), 1);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule